// File: doc/BRIEF.md
# DRAM Row/Column Strobe Sequencer

This block sits between a simple word-request port and one DRAM device whose row and column addresses share a single set of address pins. Each request carries an address of `ADDR_W` bits. The upper half selects the row and the lower half selects the column. The sequencer first opens the row by raising the row strobe with the row half on the pins. After a programmable delay it presents the column half and pulses the column strobe. Write-enable is raised only for write accesses. Read data is captured on the last cycle of each column pulse and returned as a one-cycle pulse on `rd_valid`.

Three access shapes are supported, selected by `req_mode`. A single access reads or writes one word. A nibble burst issues four column pulses under one row opening, with the two low column bits stepping mod 4 from the start column. A page burst keeps the row open and takes any further columns the requester streams in, until it signals the end of the burst. Every access keeps the row strobe high for a minimum number of cycles and then low for a minimum precharge time.

A refresh timer raises a refresh request once every `REF_PERIOD` cycles. At the next idle point, the refresh wins over new traffic and is carried out as a row-strobe-only activation of the next row in sequence.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: The row is `req_addr[ADDR_W-1:ADDR_W/2]` and the column is `req_addr[ADDR_W/2-1:0]`. The row appears on `dram_addr` when `dram_ras` rises, and the column appears when `dram_cas` rises.
- R2: `dram_cas` is high only while `dram_ras` is high. The first column pulse of a row opening is preceded by at least `T_RCD` cycles of `dram_ras` high with `dram_cas` low.
- R3: Every `dram_ras` high period lasts at least `T_RAS` cycles. Every `dram_ras` low period between two activations lasts at least `T_RP` cycles.
- R4: During reads `dram_we` stays low. Each read column produces exactly one `rd_valid` pulse, one cycle after the column pulse ends. `rd_data` carries the word the device drove on `dram_q`.
- R5: `dram_we` is high only while `dram_cas` is high in a write access. The device then stores `dram_d` at the selected row and column.
- R6: `req_mode` encodes 0 = single, 1 = nibble, 2 = page, and 3 acts as single. A nibble burst gives exactly four column pulses under one row opening. The two low column bits take the values start, start+1, start+2, start+3 (mod 4), and the upper column bits stay fixed. Beat i writes `req_wdata[i*DATA_W +: DATA_W]`.
- R7: In a page burst the first column comes from `req_addr` and its data from `req_wdata[DATA_W-1:0]`. The row stays open, `col_ready` is high only while the row is open and the column strobe is low, and each accepted `col_valid` gives one column pulse at `col_addr`. `col_end` closes the row.
- R8: Every `REF_PERIOD` cycles a refresh becomes pending. It is carried out as a row-strobe activation with no column pulse, held for at least `T_RAS`. Successive refreshes address rows 0, 1, 2 and onward, wrapping at 2^(ADDR_W/2).
- R9: While a refresh is pending and the sequencer is idle, `req_ready` is low. The refresh starts before any new request, so refreshes keep pace even under back-to-back traffic.
- R10: After reset `dram_ras`, `dram_cas`, `dram_we`, `rd_valid` and `col_ready` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 0 single, 1 nibble, 2 page, 3 single |
| req_addr | input | ADDR_W | Row (upper half) and column (lower half) |
| req_wdata | input | 4*DATA_W | Write data, beat i in slice i |
| col_ready | output | 1 | Page burst waiting for the next column or end |
| col_valid | input | 1 | Next page column present |
| col_end | input | 1 | Close the page burst |
| col_addr | input | ADDR_W/2 | Next page column |
| col_wdata | input | DATA_W | Write data for the next page column |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DATA_W | Read word |
| dram_addr | output | ADDR_W/2 | Multiplexed row/column address pins |
| dram_ras | output | 1 | Row strobe, active high |
| dram_cas | output | 1 | Column strobe, active high |
| dram_we | output | 1 | Write enable, active high |
| dram_d | output | DATA_W | Data to the device |
| dram_q | input | DATA_W | Data from the device |

## Verification
The bound checker watches the strobe rules on every cycle. It checks that the column strobe only appears under an open row, and that the row-to-column delay, the minimum row-active time and the minimum precharge time hold. It also checks that write-enable stays inside a column pulse, that refresh never pulses the column strobe, that a pending refresh blocks new requests, and that each read return follows a read pulse. The bench's scenarios are needed to show what the strobe ordering alone cannot: that the address halves land on the right cells, that nibble columns wrap in the right order, and that page bursts keep one row open for every streamed column. They also show that refresh rows advance in sequence and keep pace under continuous traffic.

// File: rtl/drc_pkg.sv
package drc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACT,
    S_CAS_ON,
    S_CAS_OFF,
    S_PAGE_WAIT,
    S_HOLD,
    S_REF,
    S_PRE
  } drc_state_e;

  typedef enum logic [1:0] {
    M_SINGLE = 2'd0,
    M_NIBBLE = 2'd1,
    M_PAGE   = 2'd2,
    M_ALT    = 2'd3
  } drc_mode_e;

  // low column bits of beat n of a nibble burst, wrapping mod 4
  function automatic logic [1:0] nib_step(input logic [1:0] start,
                                          input logic [1:0] beat);
    return start + beat;
  endfunction

  function automatic int tmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drc_refresh_timer.sv
module drc_refresh_timer #(
  parameter int PERIOD = 200,
  parameter int ROW_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  output logic             pending,
  output logic [ROW_W-1:0] row
);
  localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

  logic [TW-1:0] tcnt;
  logic          tick;

  assign tick = (tcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt    <= '0;
      pending <= 1'b0;
      row     <= '0;
    end else begin
      tcnt <= tick ? '0 : tcnt + 1'b1;
      if (tick)
        pending <= 1'b1;
      else if (ack)
        pending <= 1'b0;
      if (ack)
        row <= row + 1'b1;
    end
  end
endmodule

// File: rtl/drc_ras_meter.sv
module drc_ras_meter #(
  parameter int T_RAS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras,
  output logic ras_ok
);
  localparam int RW = $clog2(T_RAS + 1);
  localparam logic [RW-1:0] SAT  = RW'(T_RAS);
  localparam logic [RW-1:0] NEED = RW'(T_RAS - 1);

  logic [RW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hi_cnt <= '0;
    else if (!ras)
      hi_cnt <= '0;
    else if (hi_cnt != SAT)
      hi_cnt <= hi_cnt + 1'b1;
  end

  // true in the cycle that completes the minimum active time
  assign ras_ok = ras && (hi_cnt >= NEED);
endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
  import drc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 4,
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 2,
  parameter int T_CP       = 1,
  parameter int T_RAS      = 6,
  parameter int T_RP       = 3,
  parameter int REF_PERIOD = 200
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [1:0]            req_mode,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [4*DATA_W-1:0]   req_wdata,
  output logic                  col_ready,
  input  logic                  col_valid,
  input  logic                  col_end,
  input  logic [ADDR_W/2-1:0]   col_addr,
  input  logic [DATA_W-1:0]     col_wdata,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  output logic [ADDR_W/2-1:0]   dram_addr,
  output logic                  dram_ras,
  output logic                  dram_cas,
  output logic                  dram_we,
  output logic [DATA_W-1:0]     dram_d,
  input  logic [DATA_W-1:0]     dram_q
);
  localparam int HALF_W = ADDR_W / 2;
  localparam int BURST  = 4;
  localparam int MAXT   = tmax(tmax(T_RCD, T_CAS), tmax(T_CP, T_RP));
  localparam int CNT_W  = $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] LD_CAS = CNT_W'(T_CAS - 1);
  localparam logic [CNT_W-1:0] LD_CP  = CNT_W'(T_CP - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [1:0]       LAST_BEAT = 2'(BURST - 1);

  drc_state_e              state;
  drc_mode_e               mode_r;
  logic [CNT_W-1:0]        cnt;
  logic [HALF_W-1:0]       row_r;
  logic [HALF_W-1:0]       col_r;
  logic [1:0]              beat;
  logic                    wr_r;
  logic [BURST*DATA_W-1:0] wd_r;

  // named internal events, also observed by the bound checker
  logic              ref_pending;
  logic [HALF_W-1:0] ref_row;
  logic              ref_ack;
  logic              ras_ok;
  logic              fsm_idle;
  logic              in_refresh;
  logic              cnt_done;
  logic              col_phase;
  logic              rd_capture;
  logic              accept;
  logic [HALF_W-1:0] col_now;

  function automatic logic [HALF_W-1:0] row_half(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:HALF_W];
  endfunction

  function automatic logic [HALF_W-1:0] col_half(input logic [ADDR_W-1:0] a);
    return a[HALF_W-1:0];
  endfunction

  drc_refresh_timer #(
    .PERIOD (REF_PERIOD),
    .ROW_W  (HALF_W)
  ) u_refresh (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack     (ref_ack),
    .pending (ref_pending),
    .row     (ref_row)
  );

  drc_ras_meter #(
    .T_RAS (T_RAS)
  ) u_ras_meter (
    .clk    (clk),
    .rst_n  (rst_n),
    .ras    (dram_ras),
    .ras_ok (ras_ok)
  );

  assign fsm_idle   = (state == S_IDLE);
  assign in_refresh = (state == S_REF);
  assign cnt_done   = (cnt == '0);
  assign ref_ack    = fsm_idle && ref_pending;
  assign req_ready  = fsm_idle && !ref_pending;
  assign accept     = req_ready && req_valid;
  assign col_ready  = (state == S_PAGE_WAIT);
  assign col_phase  = (state == S_CAS_ON) || (state == S_CAS_OFF) ||
                      (state == S_PAGE_WAIT);
  assign col_now    = {col_r[HALF_W-1:2], nib_step(col_r[1:0], beat)};
  assign rd_capture = (state == S_CAS_ON) && cnt_done && !wr_r;

  assign dram_ras  = !fsm_idle && (state != S_PRE);
  assign dram_cas  = (state == S_CAS_ON);
  assign dram_we   = dram_cas && wr_r;
  assign dram_addr = col_phase ? col_now : row_r;
  assign dram_d    = dram_we ? wd_r[int'(beat)*DATA_W +: DATA_W] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mode_r <= M_SINGLE;
      cnt    <= '0;
      row_r  <= '0;
      col_r  <= '0;
      beat   <= '0;
      wr_r   <= 1'b0;
      wd_r   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ref_ack) begin
            state <= S_REF;
            row_r <= ref_row;
            wr_r  <= 1'b0;
          end else if (accept) begin
            state  <= S_ACT;
            cnt    <= LD_RCD;
            row_r  <= row_half(req_addr);
            col_r  <= col_half(req_addr);
            mode_r <= drc_mode_e'(req_mode);
            wr_r   <= req_write;
            wd_r   <= req_wdata;
            beat   <= '0;
          end
        end
        S_ACT: begin
          if (cnt_done) begin
            state <= S_CAS_ON;
            cnt   <= LD_CAS;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_CAS_ON: begin
          if (!cnt_done) begin
            cnt <= cnt - 1'b1;
          end else if (mode_r == M_NIBBLE && beat != LAST_BEAT) begin
            state <= S_CAS_OFF;
            cnt   <= LD_CP;
          end else if (mode_r == M_PAGE) begin
            state <= S_PAGE_WAIT;
          end else begin
            state <= S_HOLD;
          end
        end
        S_CAS_OFF: begin
          if (cnt_done) begin
            state <= S_CAS_ON;
            cnt   <= LD_CAS;
            beat  <= beat + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_PAGE_WAIT: begin
          if (col_valid) begin
            state             <= S_CAS_ON;
            cnt               <= LD_CAS;
            col_r             <= col_addr;
            wd_r[DATA_W-1:0]  <= col_wdata;
          end else if (col_end) begin
            state <= S_HOLD;
          end
        end
        S_HOLD, S_REF: begin
          if (ras_ok) begin
            state <= S_PRE;
            cnt   <= LD_RP;
          end
        end
        S_PRE: begin
          if (cnt_done)
            state <= S_IDLE;
          else
            cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_capture;
      if (rd_capture)
        rd_data <= dram_q;
    end
  end
endmodule

// File: rtl/drc_checker.sv
module drc_checker #(
  parameter int T_RCD = 2,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ras,
  input logic cas,
  input logic we,
  input logic req_ready,
  input logic col_ready,
  input logic rd_valid,
  input logic ref_pending,
  input logic fsm_idle,
  input logic in_refresh
);
  logic [7:0] hi_run;
  logic [7:0] lo_run;
  logic       cas_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run   <= '0;
      lo_run   <= 8'hFF;
      cas_seen <= 1'b0;
    end else begin
      if (ras) begin
        lo_run <= '0;
        if (hi_run != 8'hFF) hi_run <= hi_run + 1'b1;
      end else begin
        hi_run <= '0;
        if (lo_run != 8'hFF) lo_run <= lo_run + 1'b1;
      end
      if (!ras)
        cas_seen <= 1'b0;
      else if (cas)
        cas_seen <= 1'b1;
    end
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    cas |-> ras); // R2
  AST_RCD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cas && !cas_seen) |-> (hi_run >= 8'(T_RCD))); // R2
  AST_RAS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras) |-> (hi_run >= 8'(T_RAS))); // R3
  AST_RP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras) |-> (lo_run >= 8'(T_RP))); // R3
  AST_WE_IN_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> cas); // R5
  AST_RD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(cas) && !$past(we))); // R4
  AST_COL_READY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    col_ready |-> (ras && !cas)); // R7
  AST_REF_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    in_refresh |-> (ras && !cas)); // R8
  AST_REF_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pending && fsm_idle) |-> !req_ready); // R9
endmodule

bind dram_strobe_ctrl drc_checker #(
  .T_RCD (T_RCD),
  .T_RAS (T_RAS),
  .T_RP  (T_RP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ras         (dram_ras),
  .cas         (dram_cas),
  .we          (dram_we),
  .req_ready   (req_ready),
  .col_ready   (col_ready),
  .rd_valid    (rd_valid),
  .ref_pending (ref_pending),
  .fsm_idle    (fsm_idle),
  .in_refresh  (in_refresh)
);

// File: tb/dram_strobe_ctrl_test.sv
module dram_strobe_ctrl_test;
  localparam int AW = 8;
  localparam int DW = 4;
  localparam int HW = AW / 2;
  localparam int NROW = 1 << HW;
  localparam int P_RCD = 2;
  localparam int P_CAS = 2;
  localparam int P_CP  = 1;
  localparam int P_RAS = 6;
  localparam int P_RP  = 3;
  localparam int P_REF = 200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [1:0]    req_mode = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [4*DW-1:0] req_wdata = '0;
  logic          col_ready;
  logic          col_valid = 1'b0;
  logic          col_end = 1'b0;
  logic [HW-1:0] col_addr = '0;
  logic [DW-1:0] col_wdata = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [HW-1:0] dram_addr;
  logic          dram_ras, dram_cas, dram_we;
  logic [DW-1:0] dram_d, dram_q;

  always #4 clk = ~clk;

  dram_strobe_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .T_RCD(P_RCD), .T_CAS(P_CAS), .T_CP(P_CP),
    .T_RAS(P_RAS), .T_RP(P_RP), .REF_PERIOD(P_REF)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mode(req_mode), .req_addr(req_addr),
    .req_wdata(req_wdata), .col_ready(col_ready), .col_valid(col_valid),
    .col_end(col_end), .col_addr(col_addr), .col_wdata(col_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras(dram_ras), .dram_cas(dram_cas), .dram_we(dram_we),
    .dram_d(dram_d), .dram_q(dram_q)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural device model ----------------
  logic [DW-1:0] mem [NROW][NROW];
  logic [HW-1:0] row_l = '0;
  logic [HW-1:0] last_col = '0;
  bit  ras_q = 0, cas_q = 0, cas_in_run = 0, seen_pre = 0;
  int  hi_run = 0, lo_run = 0, run_cas = 0, last_run_cas = 0;
  int  ref_idx = 0, v_r2 = 0, v_r3 = 0, v_r5 = 0, cyc = 0;

  assign dram_q = (dram_cas && !dram_we) ? mem[row_l][dram_addr] : '0;

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (dram_cas && !dram_ras) v_r2++;
      if (dram_we && !dram_cas) v_r5++;
      if (dram_ras && !ras_q) begin
        if (seen_pre && lo_run < P_RP) v_r3++;
        row_l = dram_addr;
        cas_in_run = 0;
        hi_run = 0;
        run_cas = 0;
      end
      if (!dram_ras && ras_q) begin
        if (hi_run < P_RAS) v_r3++;
        if (!cas_in_run) begin
          check(row_l == HW'(ref_idx % NROW), "R8 refresh row", row_l, ref_idx % NROW);
          ref_idx++;
        end
        last_run_cas = run_cas;
        lo_run = 0;
        seen_pre = 1;
      end
      if (dram_cas && !cas_q) begin
        if (!cas_in_run && hi_run < P_RCD) v_r2++;
        cas_in_run = 1;
        run_cas++;
        last_col = dram_addr;
        if (dram_we) mem[row_l][dram_addr] = dram_d;
      end
      if (dram_ras) hi_run++; else lo_run++;
      ras_q = dram_ras;
      cas_q = dram_cas;
    end
  end

  // ---------------- scoreboard ----------------
  logic [DW-1:0] sh [NROW][NROW];
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected read return", rd_data, 0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic send_req(input bit wr, input logic [1:0] mode,
                          input logic [AW-1:0] a, input logic [4*DW-1:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_mode = mode; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic single(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input string t);
    int r = int'(a) / NROW;
    int c = int'(a) % NROW;
    if (wr) sh[r][c] = d;
    else begin exp_q.push_back(sh[r][c]); tag_q.push_back(t); end
    send_req(wr, 2'd0, a, {12'h000, d});
  endtask

  task automatic nibble(input bit wr, input logic [AW-1:0] a, input logic [4*DW-1:0] wd);
    int r = int'(a) / NROW;
    int c = int'(a) % NROW;
    for (int b = 0; b < 4; b++) begin
      int cc = (c & ~3) | ((c + b) & 3);
      if (wr) sh[r][cc] = wd[b*DW +: DW];
      else begin exp_q.push_back(sh[r][cc]); tag_q.push_back("R6 nibble read order"); end
    end
    send_req(wr, 2'd1, a, wd);
  endtask

  task automatic page(input bit wr, input int r, input int n,
                      input logic [HW-1:0] cols [8], input logic [DW-1:0] ds [8]);
    for (int k = 0; k < n; k++) begin
      if (wr) sh[r][cols[k]] = ds[k];
      else begin exp_q.push_back(sh[r][cols[k]]); tag_q.push_back("R7 page read"); end
    end
    send_req(wr, 2'd2, AW'(r * NROW + int'(cols[0])), {12'h000, ds[0]});
    for (int k = 1; k < n; k++) begin
      while (!col_ready) @(negedge clk);
      col_valid = 1'b1; col_addr = cols[k]; col_wdata = ds[k];
      @(negedge clk);
      col_valid = 1'b0;
    end
    while (!col_ready) @(negedge clk);
    col_end = 1'b1;
    @(negedge clk);
    col_end = 1'b0;
  endtask

  task automatic wait_close();
    while (dram_ras) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 200) begin @(negedge clk); guard++; end
    check(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);
  endtask

  initial begin
    logic [HW-1:0] pc [8];
    logic [DW-1:0] pd [8];
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NROW; c++) begin
        mem[r][c] = '0;
        sh[r][c] = '0;
      end
    repeat (3) @(negedge clk);
    // R10: reset values
    check(!dram_ras && !dram_cas && !dram_we, "R10 strobes low in reset",
          {dram_ras, dram_cas, dram_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rd_valid && req_ready, "R10 idle after reset", {rd_valid, req_ready}, 1);
    check(!col_ready, "R7 col_ready low outside page", col_ready, 0);

    // R1: address halves land on the right pins and cells
    single(1'b1, 8'h35, 4'hA, "R1");
    wait_close();
    check(row_l == 4'h3 && last_col == 4'h5, "R1 row/col on pins", {row_l, last_col}, 8'h35);
    single(1'b1, 8'h53, 4'h6, "R1");
    single(1'b0, 8'h35, 4'h0, "R1 read 0x35");
    single(1'b0, 8'h53, 4'h0, "R1 read 0x53");
    // R5/R4: a spread of single writes and reads
    for (int i = 0; i < 6; i++) single(1'b1, AW'(i * 41 + 7), DW'(i + 3), "R5");
    for (int i = 0; i < 6; i++) single(1'b0, AW'(i * 41 + 7), '0, "R5 write readback");
    drain();

    // R6: nibble write starting at low bits 2 wraps 2,3,0,1
    nibble(1'b1, 8'h96, 16'hD2C1);
    wait_close();
    check(last_run_cas == 4, "R6 nibble pulses in one row", last_run_cas, 4);
    single(1'b0, 8'h94, '0, "R6 wrapped beat 2 at col 4");
    single(1'b0, 8'h96, '0, "R6 beat 0 at col 6");
    nibble(1'b0, 8'h95, '0);
    drain();

    // R7: page burst with arbitrary columns in one row
    pc = '{4'h1, 4'hE, 4'h7, 4'h2, 4'h9, 4'h0, 4'h0, 4'h0};
    pd = '{4'h5, 4'hB, 4'h3, 4'hF, 4'h8, 4'h0, 4'h0, 4'h0};
    page(1'b1, 12, 5, pc, pd);
    wait_close();
    check(last_run_cas == 5, "R7 page columns in one row", last_run_cas, 5);
    pc = '{4'h9, 4'h1, 4'hE, 4'h4, 4'h7, 4'h2, 4'h0, 4'h0};
    page(1'b0, 12, 6, pc, pd);
    wait_close();
    check(last_run_cas == 6, "R7 page read columns in one row", last_run_cas, 6);
    drain();

    // R9/R8: back-to-back traffic must not starve refresh
    for (int i = 0; i < 80; i++) single(1'b0, AW'(i * 37), '0, "R9 traffic read");
    drain();
    repeat (250) @(negedge clk);
    check(ref_idx >= cyc / P_REF - 1 && ref_idx <= cyc / P_REF + 1,
          "R9 refresh count keeps pace", ref_idx, cyc / P_REF);
    check(v_r2 == 0, "R2 strobe order / RAS-to-CAS", v_r2, 0);
    check(v_r3 == 0, "R3 active/precharge minimum", v_r3, 0);
    check(v_r5 == 0, "R5 write enable inside CAS", v_r5, 0);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog expired (R10)", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule